// File: doc/BRIEF.md
# Nested Active Interrupt Tracker

This block sits beside one processor's interrupt interface and keeps track of which interrupts that processor is currently servicing. When the processor reads the acknowledge path, the block decides whether the highest-pending interrupt offered to it may preempt the one now running. If it may, the block makes it the running interrupt and asks the pending logic to drop its pending flag. Otherwise it answers with the spurious ID 1023.

Every interrupt that is taken remembers the interrupt it preempted. Together these back-links form a nesting chain. Completing the running interrupt restores the one beneath it. Completing an interrupt further down the chain removes it from the middle of the chain: a walker follows the back-links one per clock, and a busy flag stays high while the walk runs. A completed level-sensitive interrupt whose line is still high is handed back to the pending logic as a re-pend request.

Top module: `nest_active_tracker`

## Requirements
- R1: After a synchronous reset, run_id is 1023, run_prio is 0x100, every back-link holds 1023, and busy, ack_valid, clr_req and set_req are 0. Whenever run_id is 1023, run_prio is 0x100.
- R2: An acknowledge is answered with ack_id 1023 and leaves the state unchanged in three cases: hp_id is 1023, hp_id is at or above NUM_IRQ, or the priority of hp_id (a lower value is more urgent) is not strictly below run_prio.
- R3: On an accepted acknowledge, the cycle after the strobe shows ack_valid=1, ack_id=hp_id, run_id=hp_id and run_prio equal to the table priority of hp_id. The previous run_id is stored as the back-link of hp_id.
- R4: A granted acknowledge produces clr_req=1 and clr_id=ack_id in the same cycle as ack_valid. clr_all is 1 when the cfg_all_cpu bit of that interrupt is set, which means the pending bit is cleared for every processor, and 0 when only this processor's bit is to be cleared.
- R5: Completing the running ID makes its back-link the running ID on the next cycle, with that interrupt's table priority, or 0x100 if the back-link is 1023.
- R6: A completion whose ID is at or above NUM_IRQ is ignored, and so is any completion while run_id is 1023. In both cases run_id, run_prio and busy are unchanged and no set_req is raised.
- R7: Completing an ID other than the running one raises busy on the next cycle. The walker then advances one back-link per cycle. It stops when it finds the ID, which takes k cycles for an ID k places below the top, or when it reaches 1023, which takes L+1 cycles for a chain of L entries below the top. On a match, the entry above the ID inherits the ID's back-link. run_id does not change.
- R8: While busy is 1, acknowledge and completion strobes are ignored: ack_valid stays 0 and the chain is not altered.
- R9: An accepted completion of an interrupt that is level-sensitive (cfg_edge bit 0), enabled, has its line high and is targeted at this processor gives set_req=1 with set_id equal to that ID on the next cycle. Otherwise set_req stays 0.
- R10: When an acknowledge and a completion arrive in the same cycle, only the acknowledge is served and the completion is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ack_req | input | 1 | Acknowledge strobe, one cycle |
| hp_id | input | 10 | Highest-pending ID offered to this processor |
| eoi_req | input | 1 | Completion strobe, one cycle |
| eoi_id | input | 10 | ID being completed |
| prio_tbl | input | NUM_IRQ*PRIO_W | Priority of each interrupt, ID n at bits n*PRIO_W upward |
| cfg_all_cpu | input | NUM_IRQ | 1: acknowledge clears pending for all processors |
| cfg_edge | input | NUM_IRQ | 1: edge-sensitive, 0: level-sensitive |
| irq_enabled | input | NUM_IRQ | Interrupt enabled |
| irq_line | input | NUM_IRQ | Current input line level |
| irq_targeted | input | NUM_IRQ | Interrupt routed to this processor |
| ack_valid | output | 1 | Acknowledge answer valid |
| ack_id | output | 10 | Acknowledged ID or 1023 |
| run_id | output | 10 | Running interrupt ID, 1023 when idle |
| run_prio | output | PRIO_W+1 | Running priority, 0x100 when idle |
| busy | output | 1 | Chain walk in progress |
| clr_req | output | 1 | Request to clear a pending flag |
| clr_id | output | 10 | ID whose pending flag is cleared |
| clr_all | output | 1 | Clear pending for all processors |
| set_req | output | 1 | Request to set a pending flag again |
| set_id | output | 10 | ID to re-pend |

## Verification
The bench targets out-of-order completion of an ID two places down the chain, and checks afterwards that later completions step over it. A design that spliced the wrong link would resurrect the removed ID or lose the one below it. It also checks the walk length for a hit and for a miss, and that an acknowledge arriving during a walk is ignored rather than corrupting the chain. Further checks cover an acknowledge at exactly the running priority, which must be refused (a non-strict compare would nest equal priorities), an out-of-range hp_id, a simultaneous acknowledge and completion, and a level-sensitive interrupt that is still high at completion and must be re-pended while its edge-sensitive twin is not.

// File: rtl/nat_pkg.sv
package nat_pkg;
  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] NO_IRQ = '1;
  typedef logic [ID_W-1:0] irq_id_t;
endpackage

// File: rtl/nat_prio_port.sv
module nat_prio_port
  import nat_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int PRIO_W  = 8
) (
  input  logic [NUM_IRQ*PRIO_W-1:0] tbl,
  input  irq_id_t                   id,
  output logic [PRIO_W:0]           rp
);
  localparam logic [PRIO_W:0] IDLE_RP = {1'b1, {PRIO_W{1'b0}}};

  // Out-of-range IDs (including the spurious one) read as idle priority.
  always_comb begin
    rp = IDLE_RP;
    if (id < ID_W'(NUM_IRQ))
      rp = {1'b0, tbl[int'(id)*PRIO_W +: PRIO_W]};
  end
endmodule

// File: rtl/nat_link_mem.sv
module nat_link_mem
  import nat_pkg::*;
#(
  parameter int NUM_IRQ = 64
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    we,
  input  irq_id_t waddr,
  input  irq_id_t wdata,
  input  irq_id_t raddr_a,
  output irq_id_t rdata_a,
  input  irq_id_t raddr_b,
  output irq_id_t rdata_b
);
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  irq_id_t mem [NUM_IRQ];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_IRQ; i++) mem[i] <= NO_IRQ;
    end else if (we && waddr < ID_W'(NUM_IRQ)) begin
      mem[waddr[IDX_W-1:0]] <= wdata;
    end
  end

  assign rdata_a = (raddr_a < ID_W'(NUM_IRQ)) ? mem[raddr_a[IDX_W-1:0]] : NO_IRQ;
  assign rdata_b = (raddr_b < ID_W'(NUM_IRQ)) ? mem[raddr_b[IDX_W-1:0]] : NO_IRQ;
endmodule

// File: rtl/nat_chain_walk.sv
module nat_chain_walk
  import nat_pkg::*;
#(
  parameter int NUM_IRQ = 64
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  input  irq_id_t start_cur,
  input  irq_id_t start_tgt,
  input  irq_id_t link_cur,
  input  irq_id_t link_tgt,
  output logic    busy,
  output irq_id_t cur,
  output irq_id_t tgt,
  output logic    splice_we,
  output irq_id_t splice_addr,
  output irq_id_t splice_data
);
  localparam int HOP_W = $clog2(NUM_IRQ + 1);

  logic [HOP_W-1:0] hops;
  logic             hit;
  logic             dead_end;

  assign hit      = busy && (link_cur == tgt);
  assign dead_end = (link_cur == NO_IRQ) || (hops == HOP_W'(NUM_IRQ - 1));

  assign splice_we   = hit;
  assign splice_addr = cur;
  assign splice_data = link_tgt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cur  <= NO_IRQ;
      tgt  <= NO_IRQ;
      hops <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        cur  <= start_cur;
        tgt  <= start_tgt;
        hops <= '0;
      end
    end else if (hit || dead_end) begin
      busy <= 1'b0;
    end else begin
      cur  <= link_cur;
      hops <= hops + 1'b1;
    end
  end
endmodule

// File: rtl/nest_active_tracker.sv
module nest_active_tracker
  import nat_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int PRIO_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      ack_req,
  input  logic [9:0]                hp_id,
  input  logic                      eoi_req,
  input  logic [9:0]                eoi_id,
  input  logic [NUM_IRQ*PRIO_W-1:0] prio_tbl,
  input  logic [NUM_IRQ-1:0]        cfg_all_cpu,
  input  logic [NUM_IRQ-1:0]        cfg_edge,
  input  logic [NUM_IRQ-1:0]        irq_enabled,
  input  logic [NUM_IRQ-1:0]        irq_line,
  input  logic [NUM_IRQ-1:0]        irq_targeted,
  output logic                      ack_valid,
  output logic [9:0]                ack_id,
  output logic [9:0]                run_id,
  output logic [PRIO_W:0]           run_prio,
  output logic                      busy,
  output logic                      clr_req,
  output logic [9:0]                clr_id,
  output logic                      clr_all,
  output logic                      set_req,
  output logic [9:0]                set_id
);
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
  localparam logic [PRIO_W:0] IDLE_RP = {1'b1, {PRIO_W{1'b0}}};

  logic [PRIO_W:0] cand_rp, restore_rp;
  irq_id_t link_a, link_b, raddr_a;
  irq_id_t walk_cur, walk_tgt;
  irq_id_t splice_addr, splice_data;
  logic    splice_we;
  logic    hp_in_range, eoi_in_range;
  logic    ack_grant, eoi_ok, eoi_top, walk_start, refire;
  logic [IDX_W-1:0] hp_idx, eoi_idx;
  logic    mem_we;
  irq_id_t mem_waddr, mem_wdata;

  assign hp_in_range  = hp_id < ID_W'(NUM_IRQ);
  assign eoi_in_range = eoi_id < ID_W'(NUM_IRQ);
  assign hp_idx       = hp_id[IDX_W-1:0];
  assign eoi_idx      = eoi_id[IDX_W-1:0];

  nat_prio_port #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_cand_prio (
    .tbl(prio_tbl), .id(hp_id), .rp(cand_rp)
  );

  nat_prio_port #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_restore_prio (
    .tbl(prio_tbl), .id(link_a), .rp(restore_rp)
  );

  // Acknowledge wins over a same-cycle completion; nothing is taken while walking.
  assign ack_grant  = ack_req && !busy && hp_in_range && (cand_rp < run_prio);
  assign eoi_ok     = eoi_req && !busy && !ack_req && eoi_in_range && (run_id != NO_IRQ);
  assign eoi_top    = eoi_ok && (eoi_id == run_id);
  assign walk_start = eoi_ok && !eoi_top;
  assign refire     = eoi_ok && !cfg_edge[eoi_idx] && irq_enabled[eoi_idx]
                      && irq_line[eoi_idx] && irq_targeted[eoi_idx];

  assign raddr_a   = busy ? walk_cur : run_id;
  assign mem_we    = ack_grant || splice_we;
  assign mem_waddr = ack_grant ? hp_id : splice_addr;
  assign mem_wdata = ack_grant ? run_id : splice_data;

  nat_link_mem #(.NUM_IRQ(NUM_IRQ)) u_links (
    .clk(clk), .rst(rst),
    .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr_a(raddr_a), .rdata_a(link_a),
    .raddr_b(walk_tgt), .rdata_b(link_b)
  );

  nat_chain_walk #(.NUM_IRQ(NUM_IRQ)) u_walk (
    .clk(clk), .rst(rst),
    .start(walk_start), .start_cur(run_id), .start_tgt(eoi_id),
    .link_cur(link_a), .link_tgt(link_b),
    .busy(busy), .cur(walk_cur), .tgt(walk_tgt),
    .splice_we(splice_we), .splice_addr(splice_addr), .splice_data(splice_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_id    <= NO_IRQ;
      run_prio  <= IDLE_RP;
      ack_valid <= 1'b0;
      ack_id    <= NO_IRQ;
      clr_req   <= 1'b0;
      clr_id    <= NO_IRQ;
      clr_all   <= 1'b0;
      set_req   <= 1'b0;
      set_id    <= NO_IRQ;
    end else begin
      ack_valid <= ack_req && !busy;
      ack_id    <= ack_grant ? hp_id : NO_IRQ;
      clr_req   <= ack_grant;
      clr_id    <= ack_grant ? hp_id : NO_IRQ;
      clr_all   <= ack_grant && cfg_all_cpu[hp_idx];
      set_req   <= refire;
      set_id    <= refire ? eoi_id : NO_IRQ;
      if (ack_grant) begin
        run_id   <= hp_id;
        run_prio <= cand_rp;
      end else if (eoi_top) begin
        run_id   <= link_a;
        run_prio <= restore_rp;
      end
    end
  end
endmodule

// File: rtl/nest_active_tracker_chk.sv
module nest_active_tracker_chk #(
  parameter int NUM_IRQ = 64,
  parameter int PRIO_W  = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            ack_req,
  input logic            eoi_req,
  input logic [9:0]      eoi_id,
  input logic            ack_valid,
  input logic [9:0]      ack_id,
  input logic [9:0]      run_id,
  input logic [PRIO_W:0] run_prio,
  input logic            busy,
  input logic            clr_req,
  input logic [9:0]      clr_id,
  input logic            set_req
);
  localparam logic [9:0]      SPUR = 10'h3FF;
  localparam logic [PRIO_W:0] IDLE = {1'b1, {PRIO_W{1'b0}}};

  assert_idle_prio_R1: assert property (@(posedge clk) disable iff (rst)
    run_id == SPUR |-> run_prio == IDLE);

  assert_strictly_lower_R2: assert property (@(posedge clk) disable iff (rst)
    ack_valid && ack_id != SPUR |-> run_prio < $past(run_prio));

  assert_ack_runs_R3: assert property (@(posedge clk) disable iff (rst)
    ack_valid && ack_id != SPUR |-> run_id == ack_id);

  assert_clear_with_ack_R4: assert property (@(posedge clk) disable iff (rst)
    ack_valid && ack_id != SPUR |-> clr_req && clr_id == ack_id);

  assert_clear_only_on_grant_R4: assert property (@(posedge clk) disable iff (rst)
    clr_req |-> ack_valid);

  assert_range_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    !busy && !ack_req && eoi_req && eoi_id >= 10'(NUM_IRQ)
    |=> !set_req && !busy && run_id == $past(run_id));

  assert_walk_holds_run_R7: assert property (@(posedge clk) disable iff (rst)
    busy |=> run_id == $past(run_id));

  assert_busy_drops_ack_R8: assert property (@(posedge clk) disable iff (rst)
    busy && ack_req |=> !ack_valid);
endmodule

bind nest_active_tracker nest_active_tracker_chk #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_chk (
  .clk(clk), .rst(rst), .ack_req(ack_req), .eoi_req(eoi_req), .eoi_id(eoi_id),
  .ack_valid(ack_valid), .ack_id(ack_id), .run_id(run_id), .run_prio(run_prio),
  .busy(busy), .clr_req(clr_req), .clr_id(clr_id), .set_req(set_req)
);

// File: tb/nest_active_tracker_test.sv
module nest_active_tracker_test;
  localparam int NIRQ = 64;
  localparam int PW   = 8;
  localparam logic [9:0] SP = 10'd1023;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ack_req = 1'b0, eoi_req = 1'b0;
  logic [9:0] hp_id = SP, eoi_id = SP;
  logic [NIRQ*PW-1:0] prio_tbl;
  logic [NIRQ-1:0] cfg_all_cpu = '0, cfg_edge = '0, irq_enabled = '0, irq_line = '0, irq_targeted = '0;
  logic ack_valid, busy, clr_req, clr_all, set_req;
  logic [9:0] ack_id, run_id, clr_id, set_id;
  logic [PW:0] run_prio;

  int checks = 0, fails = 0, cyc = 0;

  always #5 clk = ~clk;

  nest_active_tracker #(.NUM_IRQ(NIRQ), .PRIO_W(PW)) uut (
    .clk(clk), .rst(rst), .ack_req(ack_req), .hp_id(hp_id), .eoi_req(eoi_req), .eoi_id(eoi_id),
    .prio_tbl(prio_tbl), .cfg_all_cpu(cfg_all_cpu), .cfg_edge(cfg_edge), .irq_enabled(irq_enabled),
    .irq_line(irq_line), .irq_targeted(irq_targeted), .ack_valid(ack_valid), .ack_id(ack_id),
    .run_id(run_id), .run_prio(run_prio), .busy(busy), .clr_req(clr_req), .clr_id(clr_id),
    .clr_all(clr_all), .set_req(set_req), .set_id(set_id)
  );

  function automatic int pr(int id);
    return (id >= NIRQ) ? 256 : 240 - 2 * id;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_ack(int id);
    @(negedge clk); ack_req = 1'b1; hp_id = 10'(id);
    @(posedge clk); @(negedge clk); ack_req = 1'b0;
  endtask

  task automatic do_eoi(int id);
    @(negedge clk); eoi_req = 1'b1; eoi_id = 10'(id);
    @(posedge clk); @(negedge clk); eoi_req = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  task automatic check_run(string tag, int exp);
    chk({tag, " run_id"}, run_id, exp);
    chk({tag, " run_prio"}, run_prio, pr(exp));
  endtask

  // {op(0 ack,1 eoi), id, expected run_id, expected ack_id}
  localparam logic [31:0] VEC [15] = '{
    {2'd0, 10'd5,    10'd5,    10'd5},
    {2'd0, 10'd3,    10'd5,    10'd1023},
    {2'd0, 10'd5,    10'd5,    10'd1023},
    {2'd0, 10'd10,   10'd10,   10'd10},
    {2'd0, 10'd20,   10'd20,   10'd20},
    {2'd0, 10'd30,   10'd30,   10'd30},
    {2'd1, 10'd10,   10'd30,   10'd0},
    {2'd1, 10'd30,   10'd20,   10'd0},
    {2'd1, 10'd20,   10'd5,    10'd0},
    {2'd0, 10'd1023, 10'd5,    10'd1023},
    {2'd0, 10'd100,  10'd5,    10'd1023},
    {2'd1, 10'd5,    10'd1023, 10'd0},
    {2'd1, 10'd7,    10'd1023, 10'd0},
    {2'd0, 10'd12,   10'd12,   10'd12},
    {2'd1, 10'd12,   10'd1023, 10'd0}
  };

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    for (int i = 0; i < NIRQ; i++) prio_tbl[i*PW +: PW] = 8'(pr(i));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 run_id", run_id, 1023);
    chk("R1 run_prio", run_prio, 256);
    chk("R1 busy", busy, 0);
    chk("R1 ack_valid", ack_valid, 0);
    chk("R1 clr_req", clr_req, 0);
    chk("R1 set_req", set_req, 0);

    // Vector table: R2 R3 R5 R6 R7
    for (int v = 0; v < 15; v++) begin
      logic [31:0] e;
      e = VEC[v];
      if (e[31:30] == 2'd0) begin
        do_ack(int'(e[29:20]));
        chk($sformatf("R3 vec%0d ack_valid", v), ack_valid, 1);
        chk($sformatf("R2 vec%0d ack_id", v), ack_id, int'(e[9:0]));
      end else begin
        do_eoi(int'(e[29:20]));
        chk($sformatf("R6 vec%0d ack_valid", v), ack_valid, 0);
        wait_idle(n);
      end
      chk($sformatf("R9 vec%0d set_req", v), set_req, 0);
      check_run($sformatf("R5 vec%0d", v), int'(e[19:10]));
    end

    // R4 clear scope
    cfg_all_cpu[40] = 1'b1;
    do_ack(40);
    chk("R4 clr_req", clr_req, 1);
    chk("R4 clr_id", clr_id, 40);
    chk("R4 clr_all set", clr_all, 1);
    do_ack(41);
    chk("R4 clr_id 41", clr_id, 41);
    chk("R4 clr_all clear", clr_all, 0);
    do_eoi(41); do_eoi(40);
    check_run("R5 after 40", 1023);

    // R7 walk length and splice, R8 ignore while busy
    do_ack(5); do_ack(10); do_ack(20);
    do_eoi(5);
    wait_idle(n);
    chk("R7 hit two down cycles", n, 2);
    check_run("R7 top kept", 20);
    do_eoi(50);
    chk("R7 busy after miss", busy, 1);
    ack_req = 1'b1; hp_id = 10'd30;
    @(posedge clk); @(negedge clk); ack_req = 1'b0;
    chk("R8 ack ignored", ack_valid, 0);
    chk("R8 run unchanged", run_id, 20);
    n = 1;
    while (busy) begin n++; @(negedge clk); end
    chk("R7 miss cycles", n, 2);
    do_eoi(20);
    check_run("R7 chain 20", 10);
    do_eoi(10);
    check_run("R7 5 removed", 1023);

    // R9 level re-pend
    irq_enabled[20] = 1'b1; irq_line[20] = 1'b1; irq_targeted[20] = 1'b1;
    do_ack(20);
    do_eoi(20);
    chk("R9 set_req level", set_req, 1);
    chk("R9 set_id", set_id, 20);
    cfg_edge[20] = 1'b1;
    do_ack(20);
    do_eoi(20);
    chk("R9 set_req edge", set_req, 0);

    // R10 simultaneous strobes
    do_ack(5);
    @(negedge clk); ack_req = 1'b1; hp_id = 10'd10; eoi_req = 1'b1; eoi_id = 10'd5;
    @(posedge clk); @(negedge clk); ack_req = 1'b0; eoi_req = 1'b0;
    chk("R10 ack served", ack_id, 10);
    check_run("R10 run", 10);
    do_eoi(10);
    check_run("R10 eoi dropped", 5);

    // R6 out-of-range completion while running
    cfg_edge = '0; irq_enabled = '1; irq_line = '1; irq_targeted = '1;
    do_eoi(64);
    chk("R6 no set", set_req, 0);
    chk("R6 not busy", busy, 0);
    check_run("R6 run kept", 5);
    do_eoi(5);
    check_run("R5 final", 1023);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule